// File: doc/BRIEF.md
# Frame-Synchronous Shadow Register Bank

This block holds the configuration of a display controller that composes five overlay windows. Software writes reach a set of front registers at once. The display pipeline reads a second set, the working copies. Those copies are refreshed only on the cycle in which the vertical sync pulse is high, so a change never lands in the middle of a frame. Each window has a protect bit. While that bit is set, its front values stay pending through any number of frames. Software can therefore rewrite several fields of a window and release them together by clearing protect. A global video enable combines a bit that acts immediately with a bit that is frame-synchronous. Each window also has a DMA channel enable that acts immediately.

Software must not write a window register that the window lacks. Window 0 has no alpha and no colour key. Only windows 0 to 2 have an area-size register. The write port has no back-pressure: a strobe is accepted in the cycle it is seen and never stalls. Because there is no data stream, the port is a plain strobe rather than valid/ready.

Top module: `shadow_reg_bank`

## Requirements
- R1: A write strobe updates only the front register it addresses. Working outputs do not change in any cycle in which vsync is low.
- R2: At a clock edge where vsync is high, every register of each window whose protect bit is clear takes the front value. The new value is visible on `work_o` after that edge.
- R3: At a vsync edge, a window whose protect bit is set keeps its working values. Its front values stay pending. Clearing protect applies nothing by itself; the pending values are applied at the first vsync after the clear.
- R4: When a write and vsync share a cycle, the working copy takes the front value held before that write. The written value lands in front and is applied at a later vsync. A protect write in a vsync cycle is decided with the protect value held before that write.
- R5: The window register map is at 0x10 + 8*window + index. The indexes are: 0 top-left, 1 bottom-right, 2 buffer start, 3 buffer size, 4 format, 5 alpha, 6 colour key, 7 area size. Alpha and key do not exist for window 0, and area size does not exist for windows 3 and 4. Writes to a register that does not exist are ignored, and its `work_o` slice reads zero.
- R6: Register 0x00 holds two enables: bit 0 is the immediate enable and bit 1 is the frame-synchronous enable. The frame-synchronous bit is copied at every vsync regardless of protect. `video_active_o` is high exactly when the immediate bit and the working copy of the frame-synchronous bit are both set.
- R7: Register 0x01 holds the protect mask and register 0x02 holds the channel enables, bit n belonging to window n. Both take effect at the edge of the write. `chan_en_o` shows the enables.
- R8: Reset clears all front registers, all working registers, both enables, the protect mask and the channel enables.
- R9: Writes to addresses 0x03 to 0x0F and 0x38 and above change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Write strobe, accepted in the cycle it is high |
| wr_addr | input | 8 | Register address |
| wr_data | input | 32 | Write data |
| vsync | input | 1 | One-cycle vertical sync pulse |
| video_active_o | output | 1 | Video output running |
| chan_en_o | output | 5 | DMA channel enable per window |
| work_o | output | 1280 | Working registers; window w, index r at bits (w*8+r)*32 upward |

## Verification
Two events can fall in the same cycle: a software write and the vsync copy. They are provoked both by a directed case and by random stimulus in which vsync is high in about one cycle of eight, while writes hit window registers, the protect mask and the enables. The bench model applies the copy using the front and protect values held before the edge, and then applies the write. Every working word and both control outputs are compared after each edge, so any copy of the new value, or use of the new protect value, shows up as a mismatch one frame early.

// File: rtl/shadow_bank_pkg.sv
package shadow_bank_pkg;
  localparam int ADDR_CTRL = 0;
  localparam int ADDR_PROT = 1;
  localparam int ADDR_CHAN = 2;
  localparam int WIN_BLK0  = 2;   // window block base = 0x10 >> 3

  localparam int CTRL_EN_NOW  = 0;
  localparam int CTRL_EN_SYNC = 1;

  typedef enum int {
    REG_TL = 0, REG_BR = 1, REG_BUF = 2, REG_BSZ = 3,
    REG_FMT = 4, REG_ALPHA = 5, REG_KEY = 6, REG_AREA = 7
  } win_reg_e;

  function automatic bit reg_present(int win, int r, int size_wins);
    if (r == REG_ALPHA || r == REG_KEY) return (win != 0);
    if (r == REG_AREA) return (win < size_wins);
    return 1'b1;
  endfunction
endpackage

// File: rtl/shadow_wr_decode.sv
module shadow_wr_decode #(
  parameter int NWIN = 5,
  parameter int NREG = 8,
  parameter int AW = 8,
  parameter int SIZE_WINS = 3
) (
  input  logic                 wr_en,
  input  logic [AW-1:0]        addr,
  output logic [2:0]           glb_we,
  output logic [NWIN*NREG-1:0] win_we
);
  import shadow_bank_pkg::*;
  localparam int RB = $clog2(NREG);

  logic [AW-RB-1:0] blk;
  logic [RB-1:0]    idx;
  assign blk = addr[AW-1:RB];
  assign idx = addr[RB-1:0];

  always_comb begin
    glb_we = '0;
    win_we = '0;
    if (wr_en) begin
      if (addr == AW'(ADDR_CTRL)) glb_we[0] = 1'b1;
      if (addr == AW'(ADDR_PROT)) glb_we[1] = 1'b1;
      if (addr == AW'(ADDR_CHAN)) glb_we[2] = 1'b1;
      for (int w = 0; w < NWIN; w++) begin
        if (blk == (AW-RB)'(WIN_BLK0 + w) &&
            reg_present(w, int'(idx), SIZE_WINS))
          win_we[w*NREG + int'(idx)] = 1'b1;
      end
    end
  end

  // R9
  always_comb begin
    wr_onehot_chk: assert ($onehot0({glb_we, win_we}));
  end
endmodule

// File: rtl/shadow_glb_ctrl.sv
module shadow_glb_ctrl #(
  parameter int NWIN = 5
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [2:0]      we,
  input  logic [NWIN-1:0] mask_d,
  input  logic [1:0]      ctrl_d,
  input  logic            vsync,
  output logic            video_active_o,
  output logic [NWIN-1:0] protect_o,
  output logic [NWIN-1:0] chan_en_o
);
  import shadow_bank_pkg::*;

  logic en_now_q, sync_front_q, sync_work_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_now_q     <= 1'b0;
      sync_front_q <= 1'b0;
      sync_work_q  <= 1'b0;
      protect_o    <= '0;
      chan_en_o    <= '0;
    end else begin
      if (vsync) sync_work_q <= sync_front_q;
      if (we[0]) begin
        en_now_q     <= ctrl_d[CTRL_EN_NOW];
        sync_front_q <= ctrl_d[CTRL_EN_SYNC];
      end
      if (we[1]) protect_o <= mask_d;
      if (we[2]) chan_en_o <= mask_d;
    end
  end

  assign video_active_o = en_now_q & sync_work_q;

  // R6
  sync_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sync_work_q) |-> $past(vsync));
  // R7
  prot_wr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    we[1] |=> protect_o == $past(mask_d));
  // R7
  chan_wr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    we[2] |=> chan_en_o == $past(mask_d));
endmodule

// File: rtl/shadow_win_bank.sv
module shadow_win_bank #(
  parameter int WIN = 0,
  parameter int NREG = 8,
  parameter int DW = 32,
  parameter int SIZE_WINS = 3
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NREG-1:0]    we,
  input  logic [DW-1:0]      wdata,
  input  logic               vsync,
  input  logic               protect,
  output logic [NREG*DW-1:0] work_o
);
  import shadow_bank_pkg::*;

  logic [NREG*DW-1:0] front_flat;

  for (genvar r = 0; r < NREG; r++) begin : g_reg
    if (reg_present(WIN, r, SIZE_WINS)) begin : g_live
      logic [DW-1:0] front_q, work_q;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          front_q <= '0;
          work_q  <= '0;
        end else begin
          if (vsync && !protect) work_q <= front_q;
          if (we[r]) front_q <= wdata;
        end
      end
      assign front_flat[r*DW +: DW] = front_q;
      assign work_o[r*DW +: DW]     = work_q;
    end else begin : g_absent
      assign front_flat[r*DW +: DW] = '0;
      assign work_o[r*DW +: DW]     = '0;
      // R5
      always_comb begin
        absent_we_chk: assert (!we[r]);
      end
    end
  end

  // R1
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !vsync |=> $stable(work_o));
  // R2
  copy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (vsync && !protect) |=> work_o == $past(front_flat));
  // R3
  prot_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (vsync && protect) |=> $stable(work_o));
endmodule

// File: rtl/shadow_reg_bank.sv
module shadow_reg_bank #(
  parameter int NWIN = 5,
  parameter int NREG = 8,
  parameter int DW = 32,
  parameter int AW = 8,
  parameter int SIZE_WINS = 3
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    wr_en,
  input  logic [AW-1:0]           wr_addr,
  input  logic [DW-1:0]           wr_data,
  input  logic                    vsync,
  output logic                    video_active_o,
  output logic [NWIN-1:0]         chan_en_o,
  output logic [NWIN*NREG*DW-1:0] work_o
);
  localparam int WSPAN = NREG * DW;

  logic [2:0]           glb_we;
  logic [NWIN*NREG-1:0] win_we;
  logic [NWIN-1:0]      protect;

  shadow_wr_decode #(.NWIN(NWIN), .NREG(NREG), .AW(AW), .SIZE_WINS(SIZE_WINS))
    u_dec (.wr_en(wr_en), .addr(wr_addr), .glb_we(glb_we), .win_we(win_we));

  shadow_glb_ctrl #(.NWIN(NWIN)) u_glb (
    .clk(clk), .rst_n(rst_n), .we(glb_we),
    .mask_d(wr_data[NWIN-1:0]), .ctrl_d(wr_data[1:0]),
    .vsync(vsync), .video_active_o(video_active_o),
    .protect_o(protect), .chan_en_o(chan_en_o));

  for (genvar w = 0; w < NWIN; w++) begin : g_win
    shadow_win_bank #(.WIN(w), .NREG(NREG), .DW(DW), .SIZE_WINS(SIZE_WINS)) u_bank (
      .clk(clk), .rst_n(rst_n),
      .we(win_we[w*NREG +: NREG]), .wdata(wr_data),
      .vsync(vsync), .protect(protect[w]),
      .work_o(work_o[w*WSPAN +: WSPAN]));
  end
endmodule

// File: tb/shadow_reg_bank_test.sv
module shadow_reg_bank_test;
  localparam int CLK_PERIOD = 10;
  localparam int NW = 5, NR = 8;

  logic clk = 0, rst_n = 0, wr_en = 0, vsync = 0;
  logic [7:0] wr_addr = 0;
  logic [31:0] wr_data = 0;
  logic video_active_o;
  logic [NW-1:0] chan_en_o;
  logic [NW*NR*32-1:0] work_o;

  shadow_reg_bank uut (.clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .vsync(vsync), .video_active_o(video_active_o),
    .chan_en_o(chan_en_o), .work_o(work_o));

  always #(CLK_PERIOD/2) clk = ~clk;

  int errors = 0, checks = 0;
  logic [31:0] m_front [NW][NR];
  logic [31:0] m_work  [NW][NR];
  logic [NW-1:0] m_prot, m_chan;
  logic m_now, m_sf, m_sw;

  function automatic bit present(int w, int r);
    if (r == 5 || r == 6) return w != 0;
    if (r == 7) return w < 3;
    return 1;
  endfunction

  function automatic void model_reset();
    foreach (m_front[w, r]) begin m_front[w][r] = 0; m_work[w][r] = 0; end
    m_prot = 0; m_chan = 0; m_now = 0; m_sf = 0; m_sw = 0;
  endfunction

  function automatic void model_edge(bit we, logic [7:0] a, logic [31:0] d, bit vs);
    if (vs) begin
      foreach (m_work[w, r]) if (!m_prot[w]) m_work[w][r] = m_front[w][r];
      m_sw = m_sf;
    end
    if (we) begin
      if (a == 0) begin m_now = d[0]; m_sf = d[1]; end
      else if (a == 1) m_prot = d[NW-1:0];
      else if (a == 2) m_chan = d[NW-1:0];
      else if (a >= 8'h10 && a < 8'h38) begin
        int w = (int'(a) - 16) / 8;
        int r = int'(a) % 8;
        if (present(w, r)) m_front[w][r] = d;
      end
    end
  endfunction

  task automatic chk(string tag, string what, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  task automatic compare_all(string tag);
    chk(tag, "video_active", 32'(video_active_o), 32'(m_now & m_sw));
    chk(tag, "chan_en", 32'(chan_en_o), 32'(m_chan));
    for (int w = 0; w < NW; w++)
      for (int r = 0; r < NR; r++)
        chk(tag, $sformatf("work[%0d][%0d]", w, r), work_o[(w*NR+r)*32 +: 32], m_work[w][r]);
  endtask

  task automatic step(string tag, bit we, logic [7:0] a, logic [31:0] d, bit vs);
    wr_en = we; wr_addr = a; wr_data = d; vsync = vs;
    @(posedge clk);
    model_edge(we, a, d, vs);
    @(negedge clk);
    wr_en = 0; vsync = 0;
    compare_all(tag);
  endtask

  initial begin
    #(CLK_PERIOD * 190000);
    errors++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    void'($urandom(32'd2024));
    model_reset();
    repeat (3) @(negedge clk);
    compare_all("R8 reset");
    rst_n = 1;
    @(negedge clk);
    // R1: front write, no vsync
    step("R1", 1, 8'h1A, 32'h0000_1234, 0);
    step("R1", 0, 0, 0, 0);
    // R2: vsync copies
    step("R2", 0, 0, 0, 1);
    // R3: protect window 1, rewrite, vsync holds, clear, vsync applies
    step("R3", 1, 8'h01, 32'h2, 0);
    step("R3", 1, 8'h18, 32'hAAAA_0001, 0);
    step("R3", 1, 8'h19, 32'hAAAA_0002, 0);
    step("R3", 0, 0, 0, 1);
    step("R3", 1, 8'h01, 32'h0, 0);
    step("R3", 0, 0, 0, 0);
    step("R3", 0, 0, 0, 1);
    // R4: write and vsync together
    step("R4", 1, 8'h20, 32'h5555_0000, 0);
    step("R4", 1, 8'h20, 32'h6666_0000, 1);
    step("R4", 0, 0, 0, 1);
    step("R4", 1, 8'h01, 32'h4, 0);
    step("R4", 1, 8'h20, 32'h7777_0000, 0);
    step("R4", 1, 8'h01, 32'h0, 1);
    step("R4", 0, 0, 0, 1);
    // R5: absent registers
    step("R5", 1, 8'h15, 32'hDEAD_BEEF, 0);
    step("R5", 1, 8'h16, 32'hDEAD_BEEF, 0);
    step("R5", 1, 8'h2F, 32'hDEAD_BEEF, 0);
    step("R5", 1, 8'h37, 32'hDEAD_BEEF, 1);
    // R6: video enable
    step("R6", 1, 8'h00, 32'h1, 1);
    step("R6", 1, 8'h00, 32'h3, 0);
    step("R6", 1, 8'h01, 32'h1F, 0);
    step("R6", 0, 0, 0, 1);
    step("R6", 1, 8'h00, 32'h2, 0);
    step("R6", 1, 8'h01, 32'h0, 0);
    // R7: channel enable immediate
    step("R7", 1, 8'h02, 32'h15, 0);
    step("R7", 1, 8'h02, 32'h0A, 1);
    // R9: unmapped addresses
    step("R9", 1, 8'h03, 32'hFFFF_FFFF, 0);
    step("R9", 1, 8'h0F, 32'hFFFF_FFFF, 0);
    step("R9", 1, 8'h38, 32'hFFFF_FFFF, 0);
    step("R9", 1, 8'hFF, 32'hFFFF_FFFF, 1);
    // random mix, R2 and R4
    for (int i = 0; i < 3000; i++) begin
      int sel = $urandom_range(0, 99);
      logic [7:0] a;
      if (sel < 70) a = 8'(16 + $urandom_range(0, 39));
      else if (sel < 80) a = 8'h01;
      else if (sel < 85) a = 8'h02;
      else if (sel < 90) a = 8'h00;
      else a = 8'($urandom_range(56, 255));
      step("R2/R4 random", ($urandom_range(0, 3) != 0), a, $urandom(), ($urandom_range(0, 7) == 0));
    end
    // R8: reset mid-run
    @(negedge clk);
    rst_n = 0;
    model_reset();
    @(negedge clk);
    compare_all("R8 mid-run reset");
    rst_n = 1;
    step("R8", 0, 0, 0, 1);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule